// File: doc/BRIEF.md
# Erase Command Sequence Decoder

This block sits on the write side of a NOR-style flash memory model. It watches host write cycles. Each cycle arrives as a one-clock strobe that carries an address and a data byte. The block matches those cycles against the multi-cycle erase command protocol. When a chip-erase or sector-erase sequence completes, it sends a one-cycle start pulse to an erase engine. With the pulse it sends a chip-or-sector select and the latched sector number. The block also supports a bypass mode, in which the erase sequence shrinks to two cycles.

The block holds a busy flag from the start pulse until the engine reports completion. While that flag is set, every host write is ignored. When the engine finishes, the block returns to read mode and drops the latched sector. An active-low hardware reset clears the busy flag, the bypass mode and any partial sequence at once, which aborts an erase in progress.

Command codes are fixed:
- Unlock cycle one writes 0xAA to 0x555.
- Unlock cycle two writes 0x55 to 0x2AA.
- The set-up code is 0x80.
- The chip-erase code is 0x10.
- The sector-erase code is 0x30.
- Writing 0x20 to 0x555 after the two unlock cycles enters bypass mode.
- Writing 0x90 and then 0x00 leaves bypass mode.

Only the low 11 address bits are compared against 0x555 and 0x2AA. The sector number is the top `SECT_W` bits of the address.

Top module: `erase_cmd_decoder`

## Requirements
- R1: After reset, `readMode`=1, `eraseBusy`=0, `bypassOn`=0, `eraseStart`=0 and `eraseSector`=0. A busy block never reports `readMode`=1.
- R2: The six writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 produce `eraseStart`=1 with `eraseChip`=1 in the cycle after the last write, and set `eraseBusy`. Part-way through a sequence, `readMode` is 0.
- R3: The same five lead-in writes followed by 0x30 at any address produce a start with `eraseChip`=0. The write also latches the top `SECT_W` address bits of that final write into `eraseSector`, which holds them while busy.
- R4: A write that does not match the expected next cycle returns the block to idle (`readMode`=1) and issues no start.
- R5: AA@555, 55@2AA, 20@555 sets `bypassOn` and issues no start.
- R6: In bypass mode, 0x80 (any address) followed by 0x10 starts a chip erase. 0x80 followed by 0x30 starts a sector erase of the sector given by the final write's address.
- R7: In bypass mode, 0x90 followed by 0x00 clears `bypassOn`. Afterwards a lone 0x80 leaves the block idle.
- R8: While `eraseBusy` is 1, host writes change nothing: no start, no change to sector, bypass mode or sequence position.
- R9: An `eraseDone` pulse clears `eraseBusy`, sets `readMode` and clears `eraseSector` to 0.
- R10: Asserting `rstN` during an erase immediately clears `eraseBusy` and `bypassOn` and sets `readMode`.
- R11: `eraseStart` is high for exactly one clock per accepted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous hardware reset |
| wrStb | input | 1 | One-cycle pulse marking a host write cycle |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data byte |
| eraseDone | input | 1 | Erase engine completion pulse |
| eraseStart | output | 1 | One-cycle erase start pulse |
| eraseChip | output | 1 | 1 = chip erase, 0 = sector erase |
| eraseSector | output | SECT_W | Latched sector number, 0 when idle |
| eraseBusy | output | 1 | Erase in progress |
| bypassOn | output | 1 | Bypass mode active |
| readMode | output | 1 | Idle, not busy, no sequence in progress |

## Verification
The bench builds the block with its defaults: a 16-bit address and a 4-bit sector field. With these, sector numbers such as 0x7 and 0xA lie above the 11 compared address bits. The bench can therefore confirm that a sector address does not disturb the unlock comparison, and that the latched field comes from the upper bits. The stimulus table covers both full sequences, the bypass entry and exit, a mismatch at an early and at a late step, and writes during an erase. Directed cases then cover reset values, the width of the start pulse and a reset that aborts an erase.

// File: rtl/erase_dec_pkg.sv
package erase_dec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_SETUP,
    ST_SUNL1,
    ST_SUNL2,
    ST_BYP_SET,
    ST_BYP_EXIT
  } decState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fire;
    logic chipSel;
    logic clrSect;
  } ctrlStrb_t;

  // decoded write cycle, from datapath to control
  typedef struct packed {
    logic unlock1;
    logic unlock2;
    logic setup;
    logic bypEnter;
    logic chipFull;
    logic code80;
    logic code90;
    logic code10;
    logic code30;
    logic code00;
  } wrDecode_t;

endpackage

// File: rtl/erase_dec_data.sv
module erase_dec_data
  import erase_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 4,
  parameter int CMP_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  ctrlStrb_t         strb,
  output wrDecode_t         dec,
  output logic              eraseStart,
  output logic              eraseChip,
  output logic [SECT_W-1:0] eraseSector
);

  localparam logic [CMP_W-1:0] ADR_A = CMP_W'(12'h555);
  localparam logic [CMP_W-1:0] ADR_B = CMP_W'(12'h2AA);

  logic [CMP_W-1:0] addrLow;
  logic             atA;
  logic             atB;

  assign addrLow = wrAddr[CMP_W-1:0];
  assign atA     = (addrLow == ADR_A);
  assign atB     = (addrLow == ADR_B);

  always_comb begin
    dec.unlock1  = atA && (wrData == 8'hAA);
    dec.unlock2  = atB && (wrData == 8'h55);
    dec.setup    = atA && (wrData == 8'h80);
    dec.bypEnter = atA && (wrData == 8'h20);
    dec.chipFull = atA && (wrData == 8'h10);
    dec.code80   = (wrData == 8'h80);
    dec.code90   = (wrData == 8'h90);
    dec.code10   = (wrData == 8'h10);
    dec.code30   = (wrData == 8'h30);
    dec.code00   = (wrData == 8'h00);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseStart  <= 1'b0;
      eraseChip   <= 1'b0;
      eraseSector <= '0;
    end else begin
      eraseStart <= strb.fire;
      if (strb.fire) begin
        eraseChip   <= strb.chipSel;
        eraseSector <= strb.chipSel ? '0 : wrAddr[ADDR_W-1 -: SECT_W];
      end else if (strb.clrSect) begin
        eraseSector <= '0;
      end
    end
  end

endmodule

// File: rtl/erase_dec_ctrl.sv
module erase_dec_ctrl
  import erase_dec_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrStb,
  input  logic      eraseDone,
  input  wrDecode_t dec,
  output ctrlStrb_t strb,
  output logic      eraseBusy,
  output logic      bypassOn,
  output logic      readMode
);

  decState_t state, stateNxt;
  logic      bypNxt;
  logic      take;

  assign take = wrStb && !eraseBusy;

  always_comb begin
    stateNxt     = state;
    bypNxt       = bypassOn;
    strb.fire    = 1'b0;
    strb.chipSel = 1'b0;
    strb.clrSect = eraseBusy && eraseDone;
    if (take) begin
      stateNxt = ST_IDLE;
      unique case (state)
        ST_IDLE: begin
          if (bypassOn) begin
            if (dec.code80)      stateNxt = ST_BYP_SET;
            else if (dec.code90) stateNxt = ST_BYP_EXIT;
          end else if (dec.unlock1) begin
            stateNxt = ST_UNL1;
          end
        end
        ST_UNL1:  if (dec.unlock2) stateNxt = ST_UNL2;
        ST_UNL2: begin
          if (dec.setup)         stateNxt = ST_SETUP;
          else if (dec.bypEnter) bypNxt   = 1'b1;
        end
        ST_SETUP: if (dec.unlock1) stateNxt = ST_SUNL1;
        ST_SUNL1: if (dec.unlock2) stateNxt = ST_SUNL2;
        ST_SUNL2: begin
          if (dec.chipFull) begin
            strb.fire    = 1'b1;
            strb.chipSel = 1'b1;
          end else if (dec.code30) begin
            strb.fire = 1'b1;
          end
        end
        ST_BYP_SET: begin
          if (dec.code10) begin
            strb.fire    = 1'b1;
            strb.chipSel = 1'b1;
          end else if (dec.code30) begin
            strb.fire = 1'b1;
          end
        end
        ST_BYP_EXIT: if (dec.code00) bypNxt = 1'b0;
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bypassOn  <= 1'b0;
      eraseBusy <= 1'b0;
    end else begin
      state    <= stateNxt;
      bypassOn <= bypNxt;
      if (strb.fire)                  eraseBusy <= 1'b1;
      else if (eraseBusy && eraseDone) eraseBusy <= 1'b0;
    end
  end

  assign readMode = (state == ST_IDLE) && !eraseBusy;

endmodule

// File: rtl/erase_cmd_decoder.sv
module erase_cmd_decoder
  import erase_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              eraseDone,
  output logic              eraseStart,
  output logic              eraseChip,
  output logic [SECT_W-1:0] eraseSector,
  output logic              eraseBusy,
  output logic              bypassOn,
  output logic              readMode
);

  localparam int CMP_W = 11;

  ctrlStrb_t strb;
  wrDecode_t dec;

  erase_dec_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrStb     (wrStb),
    .eraseDone (eraseDone),
    .dec       (dec),
    .strb      (strb),
    .eraseBusy (eraseBusy),
    .bypassOn  (bypassOn),
    .readMode  (readMode)
  );

  erase_dec_data #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W),
    .CMP_W  (CMP_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .strb        (strb),
    .dec         (dec),
    .eraseStart  (eraseStart),
    .eraseChip   (eraseChip),
    .eraseSector (eraseSector)
  );

endmodule

// File: rtl/erase_dec_chk.sv
module erase_dec_chk #(
  parameter int SECT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              eraseDone,
  input logic              eraseStart,
  input logic [SECT_W-1:0] eraseSector,
  input logic              eraseBusy,
  input logic              bypassOn,
  input logic              readMode
);

  a_r11_start_single: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart);

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> (eraseBusy && !$past(eraseBusy)));

  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (eraseBusy && eraseDone) |=> (!eraseBusy && eraseSector == '0));

  a_r8_quiet_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    (eraseBusy && $past(eraseBusy)) |->
      (!eraseStart && $stable(eraseSector) && $stable(bypassOn)));

  a_r1_busy_not_read: assert property (@(posedge clk) disable iff (!rstN)
    eraseBusy |-> !readMode);

endmodule

bind erase_cmd_decoder erase_dec_chk #(.SECT_W(SECT_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .eraseDone   (eraseDone),
  .eraseStart  (eraseStart),
  .eraseSector (eraseSector),
  .eraseBusy   (eraseBusy),
  .bypassOn    (bypassOn),
  .readMode    (readMode)
);

// File: tb/tb_erase_cmd_decoder.sv
`timescale 1ns/1ps
module tb_erase_cmd_decoder;

  localparam int ADDR_W = 16;
  localparam int SECT_W = 4;
  localparam int NV     = 37;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrStb = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic              eraseDone = 1'b0;
  logic              eraseStart, eraseChip, eraseBusy, bypassOn, readMode;
  logic [SECT_W-1:0] eraseSector;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  erase_cmd_decoder #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) dut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .eraseDone(eraseDone), .eraseStart(eraseStart), .eraseChip(eraseChip),
    .eraseSector(eraseSector), .eraseBusy(eraseBusy), .bypassOn(bypassOn),
    .readMode(readMode)
  );

  // {isDone, addr, data, {start,chip,busy,byp,read}, sector, req}
  localparam logic [37:0] VEC [NV] = '{
    {1'b0,16'h0555,8'hAA,5'b00000,4'h0,4'd4},  // R4 lead-in
    {1'b0,16'h02AA,8'h55,5'b00000,4'h0,4'd2},  // R2
    {1'b0,16'h0555,8'h80,5'b00000,4'h0,4'd2},
    {1'b0,16'h0555,8'hAA,5'b00000,4'h0,4'd2},
    {1'b0,16'h02AA,8'h55,5'b00000,4'h0,4'd2},
    {1'b0,16'h0555,8'h10,5'b11100,4'h0,4'd2},  // R2 chip start
    {1'b1,16'h0000,8'h00,5'b01001,4'h0,4'd9},  // R9 done
    {1'b0,16'h0555,8'hAA,5'b01000,4'h0,4'd3},
    {1'b0,16'h02AA,8'h55,5'b01000,4'h0,4'd3},
    {1'b0,16'h0555,8'h80,5'b01000,4'h0,4'd3},
    {1'b0,16'h0555,8'hAA,5'b01000,4'h0,4'd3},
    {1'b0,16'h02AA,8'h55,5'b01000,4'h0,4'd3},
    {1'b0,16'h7123,8'h30,5'b10100,4'h7,4'd3},  // R3 sector 7
    {1'b0,16'h0555,8'hAA,5'b00100,4'h7,4'd8},  // R8 ignored
    {1'b0,16'h02AA,8'h55,5'b00100,4'h7,4'd8},  // R8 ignored
    {1'b1,16'h0000,8'h00,5'b00001,4'h0,4'd9},  // R9 idle proves R8
    {1'b0,16'h0555,8'hAA,5'b00000,4'h0,4'd4},
    {1'b0,16'h02AA,8'h56,5'b00001,4'h0,4'd4},  // R4 early mismatch
    {1'b0,16'h0555,8'hAA,5'b00000,4'h0,4'd4},
    {1'b0,16'h02AA,8'h55,5'b00000,4'h0,4'd4},
    {1'b0,16'h0555,8'h80,5'b00000,4'h0,4'd4},
    {1'b0,16'h0555,8'hAA,5'b00000,4'h0,4'd4},
    {1'b0,16'h02AA,8'h55,5'b00000,4'h0,4'd4},
    {1'b0,16'h0555,8'h40,5'b00001,4'h0,4'd4},  // R4 late mismatch
    {1'b0,16'h0555,8'hAA,5'b00000,4'h0,4'd5},
    {1'b0,16'h02AA,8'h55,5'b00000,4'h0,4'd5},
    {1'b0,16'h0555,8'h20,5'b00011,4'h0,4'd5},  // R5 bypass on
    {1'b0,16'h0000,8'h80,5'b00010,4'h0,4'd6},
    {1'b0,16'h0ABC,8'h10,5'b11110,4'h0,4'd6},  // R6 chip
    {1'b1,16'h0000,8'h00,5'b01011,4'h0,4'd9},
    {1'b0,16'h0000,8'h80,5'b01010,4'h0,4'd6},
    {1'b0,16'hA000,8'h30,5'b10110,4'hA,4'd6},  // R6 sector A
    {1'b0,16'h0000,8'h90,5'b00110,4'hA,4'd8},  // R8 ignored
    {1'b1,16'h0000,8'h00,5'b00011,4'h0,4'd9},
    {1'b0,16'h0000,8'h90,5'b00010,4'h0,4'd7},
    {1'b0,16'h0000,8'h00,5'b00001,4'h0,4'd7},  // R7 bypass off
    {1'b0,16'h0000,8'h80,5'b00001,4'h0,4'd7}   // R7 lone 80 stays idle
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {start,chip,busy,byp,read,sect} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [8:0] outs();
    return {eraseStart, eraseChip, eraseBusy, bypassOn, readMode, eraseSector};
  endfunction

  task automatic pulse(input logic isDone, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    if (isDone) eraseDone = 1'b1;
    else begin wrStb = 1'b1; wrAddr = a; wrData = d; end
    @(negedge clk);
    wrStb = 1'b0;
    eraseDone = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", outs(), 9'b000010000);   // R1 reset values
    rstN = 1'b1;
    @(negedge clk);
    check("R1", outs(), 9'b000010000);

    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][37], VEC[i][36:21], VEC[i][20:13]);
      check($sformatf("R%0d row %0d", VEC[i][3:0], i), outs(), VEC[i][12:4]);
    end

    // R11: start lasts a single clock
    pulse(1'b0, 16'h0000, 8'h90);
    pulse(1'b0, 16'h0000, 8'h00);   // bypass already off: stays idle
    pulse(1'b0, 16'h0555, 8'hAA);
    pulse(1'b0, 16'h02AA, 8'h55);
    pulse(1'b0, 16'h0555, 8'h80);
    pulse(1'b0, 16'h0555, 8'hAA);
    pulse(1'b0, 16'h02AA, 8'h55);
    pulse(1'b0, 16'h5555, 8'h30);
    check("R3", outs(), 9'b101000101);
    @(negedge clk);
    check("R11", outs(), 9'b001000101);

    // R10: hardware reset aborts erase and clears bypass
    pulse(1'b1, 16'h0, 8'h0);
    pulse(1'b0, 16'h0555, 8'hAA);
    pulse(1'b0, 16'h02AA, 8'h55);
    pulse(1'b0, 16'h0555, 8'h20);
    pulse(1'b0, 16'h0000, 8'h80);
    pulse(1'b0, 16'h3000, 8'h30);
    check("R6", outs(), 9'b101100011);
    #1 rstN = 1'b0;
    #1 check("R10", outs(), 9'b000010000);
    @(negedge clk);
    rstN = 1'b1;
    pulse(1'b0, 16'h0000, 8'h80);
    check("R10", outs(), 9'b000010000);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule